// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. On a start pulse it first holds an external integrator in its cleared (discharged) state for a configurable number of clocks. It then routes the unknown input to the integrator for a fixed number of clocks. After that it moves the integrator input over to a reference of opposite polarity. While the integrator ramps back toward zero, the block counts clocks. When an external comparator reports the zero crossing, it captures the count as the conversion result.

The result is a plain binary count of `CNT_W` bits. It is proportional to the input level over the reference level, scaled by the length of the fixed run-up phase. If the ramp does not reach zero within `2**CNT_W` clocks of the run-down phase, the result clips to all ones and an overrange flag is raised. The integrator, the reference and the comparator sit outside the block. The block only drives the input-select and discharge controls and reads the comparator flag.

Top module: `dslope_seq`

## Requirements
- R1: While reset is asserted and in the cycles after it until a start is accepted, busy, done, discharge control, reference select, result and overrange all read 0.
- R2: A start accepted while idle makes busy high from the next cycle. The discharge control is then high, with the reference select low, for exactly `DISCH_CYCLES` consecutive cycles.
- R3: Directly after discharge, the input is integrated for exactly `INT_CYCLES` cycles. In those cycles busy is high and both the discharge control and the reference select are low.
- R4: After integration, the reference select (1 = reference, 0 = unknown input) goes high and stays high until the conversion ends. The comparator flag is acted on only in cycles where the reference select is high.
- R5: The result equals the number of run-down cycles that fully elapsed before the first run-down cycle in which the comparator flag is seen high. Overrange is 0 in that case.
- R6: If the flag is not seen in any of the `2**CNT_W` run-down cycles, the run-down ends after exactly that many cycles. The result becomes all ones and overrange becomes 1.
- R7: A crossing seen in the last possible run-down cycle gives an all-ones result with overrange 0.
- R8: Done is high for exactly one cycle, the first cycle in which the new result is visible. Busy is low in that cycle.
- R9: A start pulse received while busy has no effect on phase lengths or result, and it does not trigger a second conversion.
- R10: Result and overrange keep their values through a following conversion, until that conversion completes.
- R11: A start pulse arriving in the done cycle is accepted and begins a new discharge phase in the next cycle.
- R12: A comparator flag that is high during discharge or integration has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, one-cycle pulse |
| zero_cross_i | input | 1 | Comparator flag: integrator output has reached zero |
| sel_ref_o | output | 1 | Integrator input select: 1 = reference, 0 = unknown input |
| int_clear_o | output | 1 | Integrator discharge control |
| result_o | output | CNT_W | Latched conversion count |
| overrange_o | output | 1 | Latched overrange flag |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of events can land in the same cycle. The first pair is a comparator crossing and the run-down timeout on the final count. It is provoked by choosing an input to reference ratio that places the crossing exactly on count `2**CNT_W - 1`. It is judged on the overrange flag, which must stay clear even though the result is all ones. The second pair is a completion and a fresh start: the bench raises start during the done cycle and expects discharge in the very next cycle, while the just-latched result still holds. An integrator model in the bench drives the comparator from a sweep of input and reference levels. Each expected count is computed as the ceiling of input times run-up length over reference.

// File: rtl/dslope_pkg.sv
// Shared types for the dual-slope converter sequencer.
package dslope_pkg;

    // Conversion phase; encoding is internal to the block.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DISCH = 2'd1,
        PH_INTEG = 2'd2,
        PH_DEINT = 2'd3
    } phase_e;

endpackage

// File: rtl/dslope_phase_timer.sv
// Phase timer: a free-running up counter that is cleared whenever the
// sequencer enters a new phase.
// Assumes: the controller never lets it run past its width (the limits are
// checked against terminal values sized from the longest phase).
module dslope_phase_timer #(
    parameter int TMR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [TMR_W-1:0] cnt_o
);

    // Count clocks within the current phase; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/dslope_fsm.sv
// Sequencer: walks idle -> discharge -> run-up -> run-down -> idle.
// It decides the end of each phase from the phase timer. In run-down it
// raises a latch request on a comparator crossing or on timeout.
// Assumes: the timer restarts at zero on the cycle after tmr_clr_o is high.
module dslope_fsm
    import dslope_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int INT_CYCLES   = 256,
    parameter int DISCH_CYCLES = 4,
    parameter int TMR_W        = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             zero_cross_i,
    input  logic [TMR_W-1:0] cnt_i,
    output phase_e           phase_o,
    output logic             tmr_clr_o,
    output logic             latch_o,
    output logic             ovf_o
);

    localparam logic [TMR_W-1:0] DISCH_LAST = TMR_W'(DISCH_CYCLES - 1);
    localparam logic [TMR_W-1:0] INT_LAST   = TMR_W'(INT_CYCLES - 1);
    localparam logic [TMR_W-1:0] DEINT_LAST = TMR_W'((2 ** CNT_W) - 1);

    phase_e phase_q, phase_d;

    // Next-phase and control decode for the current phase.
    always_comb begin
        phase_d   = phase_q;
        tmr_clr_o = 1'b0;
        latch_o   = 1'b0;
        ovf_o     = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                tmr_clr_o = 1'b1;
                if (start_i) phase_d = PH_DISCH;
            end
            PH_DISCH: begin
                if (cnt_i == DISCH_LAST) begin
                    phase_d   = PH_INTEG;
                    tmr_clr_o = 1'b1;
                end
            end
            PH_INTEG: begin
                if (cnt_i == INT_LAST) begin
                    phase_d   = PH_DEINT;
                    tmr_clr_o = 1'b1;
                end
            end
            PH_DEINT: begin
                if (zero_cross_i) begin
                    latch_o = 1'b1;
                    phase_d = PH_IDLE;
                end else if (cnt_i == DEINT_LAST) begin
                    latch_o = 1'b1;
                    ovf_o   = 1'b1;
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/dslope_result_latch.sv
// Output latch: captures the run-down count, or all ones on overrange, and
// pulses done for the cycle in which the new value first appears.
// Assumes: latch_i is high for a single cycle per conversion.
module dslope_result_latch #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_i,
    input  logic             ovf_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] result_o,
    output logic             overrange_o,
    output logic             done_o
);

    // Hold result and flag between conversions; update on latch request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o    <= '0;
            overrange_o <= 1'b0;
        end else if (latch_i) begin
            result_o    <= ovf_i ? '1 : cnt_i;
            overrange_o <= ovf_i;
        end
    end

    // One-cycle completion pulse, aligned with the new result.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= latch_i;
    end

endmodule

// File: rtl/dslope_seq.sv
// Dual-slope converter sequencer top. It ties the phase timer, the
// sequencer and the output latch together, and decodes the analog controls
// from the phase.
// Assumes: zero_cross_i is synchronous to clk; start_i is a pulse.
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int INT_CYCLES   = 256,
    parameter int DISCH_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             zero_cross_i,
    output logic             sel_ref_o,
    output logic             int_clear_o,
    output logic [CNT_W-1:0] result_o,
    output logic             overrange_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int DEINT_SPAN = 2 ** CNT_W;
    localparam int SPAN_A     = (INT_CYCLES > DISCH_CYCLES) ? INT_CYCLES : DISCH_CYCLES;
    localparam int SPAN_MAX   = (SPAN_A > DEINT_SPAN) ? SPAN_A : DEINT_SPAN;
    localparam int TMR_W      = $clog2(SPAN_MAX + 1);

    initial begin
        if (INT_CYCLES < 1 || DISCH_CYCLES < 1 || CNT_W < 1)
            $error("dslope_seq: phase lengths and width must be at least 1");
    end

    phase_e           phase;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_clr;
    logic             latch_req;
    logic             ovf_req;

    dslope_phase_timer #(.TMR_W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (tmr_cnt)
    );

    dslope_fsm #(
        .CNT_W        (CNT_W),
        .INT_CYCLES   (INT_CYCLES),
        .DISCH_CYCLES (DISCH_CYCLES),
        .TMR_W        (TMR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .zero_cross_i (zero_cross_i),
        .cnt_i        (tmr_cnt),
        .phase_o      (phase),
        .tmr_clr_o    (tmr_clr),
        .latch_o      (latch_req),
        .ovf_o        (ovf_req)
    );

    dslope_result_latch #(.CNT_W(CNT_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_i     (latch_req),
        .ovf_i       (ovf_req),
        .cnt_i       (tmr_cnt[CNT_W-1:0]),
        .result_o    (result_o),
        .overrange_o (overrange_o),
        .done_o      (done_o)
    );

    // Analog control and status decode from the current phase.
    always_comb begin
        busy_o      = (phase != PH_IDLE);
        int_clear_o = (phase == PH_DISCH);
        sel_ref_o   = (phase == PH_DEINT);
    end

endmodule

// File: rtl/dslope_seq_checker.sv
// Property checker for dslope_seq, attached by bind. It observes ports only.
module dslope_seq_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_ref_o,
    input logic             int_clear_o,
    input logic [CNT_W-1:0] result_o,
    input logic             overrange_o,
    input logic             busy_o,
    input logic             done_o
);

    assert_clear_in_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_clear_o |-> (busy_o && !sel_ref_o));

    assert_ref_in_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ref_o |-> busy_o);

    assert_ovr_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overrange_o |-> (result_o == {CNT_W{1'b1}}));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || ($stable(result_o) && $stable(overrange_o))));

endmodule

bind dslope_seq dslope_seq_checker #(.CNT_W(CNT_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_ref_o   (sel_ref_o),
    .int_clear_o (int_clear_o),
    .result_o    (result_o),
    .overrange_o (overrange_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/dslope_seq_bench.sv
// Bench: small configuration, integrator modelled arithmetically, sweep of
// input and reference levels plus directed corner cases.
module dslope_seq_bench;

    localparam int CW    = 4;
    localparam int NINT  = 8;
    localparam int NDIS  = 3;
    localparam int SPAN  = 2 ** CW;
    localparam int ALL1  = SPAN - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          zero_cross_i = 1'b0;
    logic          sel_ref_o, int_clear_o, overrange_o, busy_o, done_o;
    logic [CW-1:0] result_o;

    int tests = 0;
    int fails = 0;
    int vin_m = 0;
    int vref_m = 1;
    int level = 0;
    bit noise = 1'b0;
    int prev_res = 0;
    int prev_ovr = 0;

    always #5 clk = ~clk;

    dslope_seq #(.CNT_W(CW), .INT_CYCLES(NINT), .DISCH_CYCLES(NDIS)) u_dslope_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .zero_cross_i (zero_cross_i),
        .sel_ref_o    (sel_ref_o),
        .int_clear_o  (int_clear_o),
        .result_o     (result_o),
        .overrange_o  (overrange_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    // Integrator and comparator model, evaluated mid-cycle.
    always @(negedge clk) begin
        zero_cross_i <= (sel_ref_o && level <= 0) || (noise && !sel_ref_o);
        if (int_clear_o)   level = 0;
        else if (sel_ref_o) level = level - vref_m;
        else if (busy_o)    level = level + vin_m;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One conversion. Enters and leaves on a negedge.
    task automatic conv(input int vin, input int vref, input bit launched,
                        input bit chain, input bit poke, input bit noisy);
        int m, exp_res, exp_ovr, exp_nd;
        int nc = 0, ni = 0, nd = 0, guard = 0;
        bit held_checked = 1'b0;
        vin_m = vin; vref_m = vref; noise = noisy;
        m = (vin * NINT + vref - 1) / vref;
        if (m > ALL1) begin exp_res = ALL1; exp_ovr = 1; exp_nd = SPAN; end
        else          begin exp_res = m;    exp_ovr = 0; exp_nd = m + 1; end
        if (!launched) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o && guard < 200) begin
            if (int_clear_o) nc++;
            else if (sel_ref_o) nd++;
            else if (busy_o) ni++;
            if (!held_checked && sel_ref_o) begin
                held_checked = 1'b1;
                chk(int'(result_o) == prev_res, "R10 result held", int'(result_o), prev_res);
                chk(int'(overrange_o) == prev_ovr, "R10 overrange held", int'(overrange_o), prev_ovr);
            end
            start_i = poke && (ni == 2 || nd == 1);
            guard++;
            @(negedge clk);
        end
        start_i = 1'b0;
        noise = 1'b0;
        chk(nc == NDIS, "R2 discharge length", nc, NDIS);
        chk(ni == NINT, "R3 run-up length", ni, NINT);
        chk(nd == exp_nd, "R4/R6 run-down length", nd, exp_nd);
        chk(int'(result_o) == exp_res, noisy ? "R12 result" : "R5 result", int'(result_o), exp_res);
        chk(int'(overrange_o) == exp_ovr, (m == ALL1) ? "R7 overrange" : "R6 overrange",
            int'(overrange_o), exp_ovr);
        chk(!busy_o, "R8 busy low at done", int'(busy_o), 0);
        prev_res = exp_res; prev_ovr = exp_ovr;
        if (chain) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o, "R8 done one cycle", int'(done_o), 0);
        if (chain) begin
            chk(busy_o && int_clear_o, "R11 start in done cycle", int'(int_clear_o), 1);
        end else begin
            chk(!busy_o, poke ? "R9 no extra conversion" : "R9 idle after done", int'(busy_o), 0);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy_o && !done_o && !int_clear_o && !sel_ref_o, "R1 idle controls", int'(busy_o), 0);
        chk(result_o == '0 && !overrange_o, "R1 result cleared", int'(result_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && result_o == '0 && !overrange_o, "R1 idle after release", int'(busy_o), 0);

        // Sweep of input and reference levels (R4, R5, R6).
        for (int vr = 1; vr <= 4; vr++) begin
            for (int vi = 0; vi <= 7; vi++) begin
                conv(vi, vr, 1'b0, 1'b0, 1'b0, 1'b0);
            end
        end
        // Crossing exactly on the last run-down count (R7).
        conv(15, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        // One past it: timeout (R6).
        conv(16, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        // Small count, then starts while busy (R9).
        conv(1, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        conv(9, 8, 1'b0, 1'b0, 1'b1, 1'b0);
        // Comparator noise outside run-down (R12).
        conv(5, 4, 1'b0, 1'b0, 1'b0, 1'b1);
        conv(0, 3, 1'b0, 1'b0, 1'b0, 1'b1);
        // Back-to-back with start in the done cycle (R11), results held (R10).
        conv(3, 2, 1'b0, 1'b1, 1'b0, 1'b0);
        conv(7, 1, 1'b1, 1'b1, 1'b0, 1'b0);
        conv(2, 3, 1'b1, 1'b0, 1'b0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule